// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer guarded by a key. It has a 16-bit counter that advances on ticks. A tick comes either from the core clock or from an external tick strobe, and it can be divided by four first. The counter's interval is taken from one of four counter taps. When that interval runs out, the block sends one of three single-cycle pulses: a system reset request, a non-maskable interrupt request, or an ordinary timer interrupt. The last one is used when the block runs as a general-purpose interval timer.

Software reaches the block through a single 16-bit control register. A write is accepted only when its upper byte holds the key 0x5A. Any other upper byte is rejected: it changes nothing and sends a key-violation pulse. Reads return 0x69 in the upper byte. A read-modify-write that forgets to put the key back is therefore caught as a violation. Software can never read the counter. Software kicks the watchdog by writing the key with the clear bit set.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `rdData` reads 0x6900 and all four pulse outputs are low. This selects watchdog mode, reset action, tap 15, the core clock, no prescale and no hold.
- R2: When a write has 0x5A in `wrData[15:8]`, the configuration is updated from its low byte. Bit 7 is hold, bit 6 is interval-timer mode, bit 5 is the NMI action, bit 3 selects the external tick, bit 2 selects divide-by-4, and bits 1:0 are the tap select. The new configuration appears on `rdData[7:0]` from the next cycle, with bit 4 read as 0 and 0x69 in `rdData[15:8]`.
- R3: A write whose upper byte is not 0x5A gives a `keyViolIrq` pulse one cycle long in the next cycle. This includes the read-back value 0x69. Such a write leaves the configuration and the counter as they were.
- R4: A keyed write with bit 4 set clears the counter and the prescaler. A full interval then starts again from that write.
- R5: Tap select 0, 1, 2 and 3 give intervals of 32768, 8192, 512 and 64 ticks.
- R6: In watchdog mode, expiry gives a single-cycle `sysRstReq` when the action bit is 0 and `nmiReq` when it is 1. The counter then restarts from zero.
- R7: In interval-timer mode, expiry gives a single-cycle `timerIrq` and never a reset or NMI. Expiries repeat once per interval.
- R8: While hold is set, the counter and prescaler keep their values and no expiry occurs. Clearing hold lets counting continue from the value it had.
- R9: With the external source selected, only cycles in which `extTick` is high advance the counter. With divide-by-4, one tick occurs for every four source events.
- R10: An expiry pulse appears in the cycle after the clock edge at which the tick completing the interval was taken. With tap 3, no prescale and the core clock, that is the 64th edge after a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 16 | Write data: key in [15:8], control fields in [7:0] |
| extTick | input | 1 | External count source enable, sampled each cycle |
| rdData | output | 16 | Read-back value: 0x69 and the current configuration |
| sysRstReq | output | 1 | Reset request pulse on watchdog expiry |
| nmiReq | output | 1 | Non-maskable interrupt pulse on watchdog expiry |
| timerIrq | output | 1 | Interval-timer interrupt pulse |
| keyViolIrq | output | 1 | Key-violation pulse |

## Verification
The properties assume that `wrData` and `wrEn` are stable around each clock edge. They also assume that the write strobe lasts one cycle for each access, so each write can be tied to exactly one response in the following cycle. The stimulus changes inputs only on the falling edge and holds `wrEn` for a single cycle in every write. `extTick` is toggled only on falling edges, so each source event is seen by exactly one rising edge. Writes are never issued during reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_WRITE = 8'h5A;
  localparam logic [KEY_W-1:0] KEY_READ = 8'h69;

  // Live configuration held by the control module
  typedef struct packed {
    logic       hold;
    logic       intervalMode;
    logic       nmiAction;
    logic       srcExt;
    logic       preDiv4;
    logic [1:0] tapSel;
  } wdtCfg_t;

  // Strobes and configuration passed from control to datapath
  typedef struct packed {
    logic    clearCnt;
    wdtCfg_t cfg;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output wdtStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              keyViolIrq
);
  wdtCfg_t cfgQ;
  wdtCfg_t cfgNext;
  logic keyOk;

  assign keyOk = (wrData[DATA_W-1 -: KEY_W] == KEY_WRITE);

  always_comb begin
    cfgNext.hold         = wrData[7];
    cfgNext.intervalMode = wrData[6];
    cfgNext.nmiAction    = wrData[5];
    cfgNext.srcExt       = wrData[3];
    cfgNext.preDiv4      = wrData[2];
    cfgNext.tapSel       = wrData[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ       <= '0;
      keyViolIrq <= 1'b0;
    end else begin
      keyViolIrq <= wrEn && !keyOk;
      if (wrEn && keyOk) cfgQ <= cfgNext;
    end
  end

  // Datapath uses the configuration in force during this cycle
  assign strobe.clearCnt = wrEn && keyOk && wrData[4];
  assign strobe.cfg      = cfgQ;

  assign rdData = {KEY_READ, cfgQ.hold, cfgQ.intervalMode, cfgQ.nmiAction,
                   1'b0, cfgQ.srcExt, cfgQ.preDiv4, cfgQ.tapSel};
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 2,
  parameter int TAP_0 = 15,
  parameter int TAP_1 = 13,
  parameter int TAP_2 = 9,
  parameter int TAP_3 = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t strobe,
  input  logic       extTick,
  output logic       sysRstReq,
  output logic       nmiReq,
  output logic       timerIrq
);
  localparam int NUM_TAPS = 4;

  function automatic int tapBit(input int idx);
    case (idx)
      0:       return TAP_0;
      1:       return TAP_1;
      2:       return TAP_2;
      default: return TAP_3;
    endcase
  endfunction

  logic [CNT_W-1:0] cntQ;
  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] tapMask [NUM_TAPS];
  logic [CNT_W-1:0] selMask;
  logic srcOn, advance, preDone, tick, wrap;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_mask
    assign tapMask[g] = (CNT_W'(1) << tapBit(g)) - CNT_W'(1);
  end

  assign selMask = tapMask[strobe.cfg.tapSel];
  assign srcOn   = strobe.cfg.srcExt ? extTick : 1'b1;
  assign advance = !strobe.cfg.hold && srcOn && !strobe.clearCnt;
  assign preDone = strobe.cfg.preDiv4 ? (preQ == '1) : 1'b1;
  assign tick    = advance && preDone;
  assign wrap    = tick && ((cntQ & selMask) == selMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      preQ      <= '0;
      sysRstReq <= 1'b0;
      nmiReq    <= 1'b0;
      timerIrq  <= 1'b0;
    end else begin
      sysRstReq <= wrap && !strobe.cfg.intervalMode && !strobe.cfg.nmiAction;
      nmiReq    <= wrap && !strobe.cfg.intervalMode && strobe.cfg.nmiAction;
      timerIrq  <= wrap && strobe.cfg.intervalMode;
      if (strobe.clearCnt) begin
        cntQ <= '0;
        preQ <= '0;
      end else begin
        if (advance) preQ <= strobe.cfg.preDiv4 ? preQ + PRE_W'(1) : '0;
        if (tick)    cntQ <= wrap ? '0 : cntQ + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        extTick,
  output logic [15:0] rdData,
  output logic        sysRstReq,
  output logic        nmiReq,
  output logic        timerIrq,
  output logic        keyViolIrq
);
  wdtStrobe_t strobe;

  wdt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .strobe     (strobe),
    .rdData     (rdData),
    .keyViolIrq (keyViolIrq)
  );

  wdt_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .extTick   (extTick),
    .sysRstReq (sysRstReq),
    .nmiReq    (nmiReq),
    .timerIrq  (timerIrq)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        sysRstReq,
  input logic        nmiReq,
  input logic        timerIrq,
  input logic        keyViolIrq
);
  logic badWr, goodWr;
  assign badWr  = wrEn && (wrData[15:8] != 8'h5A);
  assign goodWr = wrEn && (wrData[15:8] == 8'h5A);

  a_r3_bad_key_flags: assert property (@(posedge clk) disable iff (!rstN)
    badWr |=> keyViolIrq);
  a_r3_bad_key_keeps_cfg: assert property (@(posedge clk) disable iff (!rstN)
    badWr |=> $stable(rdData));
  a_r3_good_key_quiet: assert property (@(posedge clk) disable iff (!rstN)
    goodWr |=> !keyViolIrq);
  a_r2_cfg_loaded: assert property (@(posedge clk) disable iff (!rstN)
    goodWr |=> (rdData[7:0] == ($past(wrData[7:0]) & 8'hEF)));
  a_r8_hold_blocks_expiry: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7] |=> !(sysRstReq || nmiReq || timerIrq));
  a_r6_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sysRstReq, nmiReq, timerIrq}));
  a_r6_reset_route: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> (!$past(rdData[6]) && !$past(rdData[5])));
  a_r6_nmi_route: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> (!$past(rdData[6]) && $past(rdData[5])));
  a_r7_timer_route: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |-> $past(rdData[6]));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (sysRstReq || nmiReq) |=> !(sysRstReq || nmiReq));
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .sysRstReq  (sysRstReq),
  .nmiReq     (nmiReq),
  .timerIrq   (timerIrq),
  .keyViolIrq (keyViolIrq)
);

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic extTick = 1'b0;
  logic extEn = 1'b0;
  logic [15:0] rdData;
  logic sysRstReq, nmiReq, timerIrq, keyViolIrq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyed_wdt dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .extTick(extTick),
    .rdData(rdData), .sysRstReq(sysRstReq), .nmiReq(nmiReq),
    .timerIrq(timerIrq), .keyViolIrq(keyViolIrq)
  );

  always @(negedge clk) extTick <= extEn ? ~extTick : 1'b0;

  // Behavioural reference model
  int mCnt = 0;
  int mPre = 0;
  logic [7:0] mCfg = 8'h00;
  bit eRst = 0, eNmi = 0, eIrq = 0, eViol = 0;

  function automatic int tapOf(input logic [1:0] s);
    case (s)
      2'd0: return 15;
      2'd1: return 13;
      2'd2: return 9;
      default: return 6;
    endcase
  endfunction

  always @(posedge clk) begin
    bit keyOk, clr, tick, srcOn;
    int lim;
    if (!rstN) begin
      mCnt = 0; mPre = 0; mCfg = 8'h00;
      eRst = 0; eNmi = 0; eIrq = 0; eViol = 0;
    end else begin
      keyOk = (wrData[15:8] == 8'h5A);
      clr = wrEn && keyOk && wrData[4];
      eRst = 0; eNmi = 0; eIrq = 0;
      eViol = wrEn && !keyOk;
      srcOn = mCfg[3] ? extTick : 1'b1;
      if (clr) begin
        mCnt = 0; mPre = 0;
      end else if (!mCfg[7] && srcOn) begin
        tick = mCfg[2] ? (mPre == 3) : 1'b1;
        mPre = mCfg[2] ? (mPre + 1) % 4 : 0;
        if (tick) begin
          lim = 1 << tapOf(mCfg[1:0]);
          if ((mCnt % lim) == lim - 1) begin
            mCnt = 0;
            if (mCfg[6]) eIrq = 1;
            else if (mCfg[5]) eNmi = 1;
            else eRst = 1;
          end else mCnt = mCnt + 1;
        end
      end
      if (wrEn && keyOk) mCfg = wrData[7:0] & 8'hEF;
    end
  end

  // Cycle compare against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (rdData !== {8'h69, mCfg}) begin
        fails++; $display("FAIL R2 rdData actual=%h expected=%h", rdData, {8'h69, mCfg});
      end else if (keyViolIrq !== eViol) begin
        fails++; $display("FAIL R3 keyViolIrq actual=%b expected=%b", keyViolIrq, eViol);
      end else if (sysRstReq !== eRst || nmiReq !== eNmi) begin
        fails++; $display("FAIL R6 rst/nmi actual=%b%b expected=%b%b", sysRstReq, nmiReq, eRst, eNmi);
      end else if (timerIrq !== eIrq) begin
        fails++; $display("FAIL R7 timerIrq actual=%b expected=%b", timerIrq, eIrq);
      end
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 16'h0;
  endtask

  // Counts cycles to the next expiry pulse; which: 1 reset, 2 nmi, 3 timer
  task automatic measure(output int n, output int which);
    n = 0; which = 0;
    while (n < 40000) begin
      @(negedge clk);
      n++;
      if (sysRstReq) begin which = 1; break; end
      if (nmiReq) begin which = 2; break; end
      if (timerIrq) begin which = 3; break; end
    end
  endtask

  task automatic countPulses(input int len, output int p);
    p = 0;
    repeat (len) begin
      @(negedge clk);
      if (sysRstReq || nmiReq || timerIrq) p++;
    end
  endtask

  initial begin
    int n, w, p;
    repeat (3) @(negedge clk);
    check("R1 rdData", rdData, 16'h6900);
    check("R1 pulses", {sysRstReq, nmiReq, timerIrq, keyViolIrq}, 0);
    rstN = 1'b1;
    measure(n, w);
    check("R5 tap0 interval", n, 32768);
    check("R6 default reset action", w, 1);

    wr(16'h5A13);
    measure(n, w);
    check("R10 tap3 latency", n, 64);
    check("R6 reset action", w, 1);

    wr(16'h5A33);
    measure(n, w);
    check("R6 nmi interval", n, 64);
    check("R6 nmi action", w, 2);

    wr(16'h5A53);
    measure(n, w);
    check("R7 timer interval", n, 64);
    check("R7 timer action", w, 3);
    measure(n, w);
    check("R7 periodic", n, 64);

    wr(16'h5A52);
    measure(n, w);
    check("R5 tap2 interval", n, 512);
    wr(16'h5A51);
    measure(n, w);
    check("R5 tap1 interval", n, 8192);

    wr(16'h5A57);
    measure(n, w);
    check("R9 div4 interval", n, 256);

    extEn = 1'b1;
    wr(16'h5A5B);
    measure(n, w);
    check("R9 ext tick interval", (n == 127 || n == 128) ? 1 : 0, 1);
    extEn = 1'b0;
    @(negedge clk);
    wr(16'h5A5B);
    countPulses(300, p);
    check("R9 ext idle no expiry", p, 0);

    wr(16'h5A53);
    repeat (20) @(negedge clk);
    wr(16'h5AC3);
    check("R2 readback", rdData, 16'h69C3);
    countPulses(200, p);
    check("R8 hold no expiry", p, 0);
    wr(16'h5A43);
    measure(n, w);
    check("R8 resume keeps count", n, 43);

    wr(16'h5A53);
    repeat (30) @(negedge clk);
    wr(16'h1253);
    check("R3 violation pulse", keyViolIrq, 1);
    check("R3 cfg unchanged", rdData, 16'h6943);
    measure(n, w);
    check("R3 counter not cleared", n, 33);
    wr(16'h6943);
    check("R3 read key rejected", keyViolIrq, 1);

    wr(16'h5A53);
    repeat (40) @(negedge clk);
    wr(16'h5A53);
    check("R4 clear bit reads zero", rdData[4], 0);
    measure(n, w);
    check("R4 clear restarts interval", n, 64);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule